// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a bank of small control registers for the I/O support logic of a workstation. A simple synchronous register bus reaches it. Each register has its own region select line and a fixed access width. Most registers only store what is written. Three of them act on a write instead:

- The first auxiliary byte produces a one-cycle terminal-count strobe for a floppy controller.
- The second auxiliary byte combines a power-off request, a write-one-to-clear interrupt acknowledge and a power-fail status bit that the block itself keeps.
- A system-control word turns a reset command into a one-cycle reset request and leaves a status code that stays set.

A power-failing input updates the power-fail status, but only while the power interrupt is enabled. The interrupt output reports that status, gated by the enable. The block has two resets. The asynchronous hard reset clears everything. The synchronous soft reset clears only the configuration, modem and auxiliary bytes, and keeps the diagnostic byte, the LED halfword and the system-control status.

Region select index, with the access width in brackets: 0 configuration (byte), 1 diagnostic (byte), 2 modem control (byte), 3 LED (16-bit), 4 system control (32-bit), 5 auxiliary-1 (byte), 6 auxiliary-2 (byte). Size codes: 0 is a byte, 1 is a halfword, 2 is a word. Read data is registered and appears the cycle after a read request. The pulse outputs rise in the cycle after the write that causes them.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `pf_irq` is high exactly when auxiliary-2 bit 5 and configuration bit 3 are both set. It reflects the stored registers, so it follows a configuration write, an auxiliary-2 write or a power-failing event by one cycle.
- R2: A change on `pwr_failing` is detected against the value sampled the cycle before. When a change is seen, auxiliary-2 bit 5 is loaded with `pwr_failing` AND the stored configuration bit 3 (the value before any write in that same cycle). This update is applied after any auxiliary-2 write in that cycle. Without a change, bit 5 is left alone.
- R3: An auxiliary-1 write stores the data with bit 1 forced to 0. When data bit 1 is set, `tc_pulse` is high for exactly the next cycle.
- R4: An auxiliary-2 write stores data bits 1:0 together with the existing bit 5; all other bits are 0. When data bit 1 is set, the stored value is reduced to data bit 0 alone, which clears both bit 5 and bit 1.
- R5: An auxiliary-2 write with data bit 0 set raises `shutdown_req` for exactly the next cycle.
- R6: A system-control write at offset 0 with data bit 0 set loads the register with 0x02 and raises `reset_req` for exactly the next cycle. A system-control write with bit 0 clear changes nothing.
- R7: Any access at a nonzero offset, including the LED and system-control regions, is dropped: a read returns 0 and a write changes nothing.
- R8: An access whose size code differs from the region's width, or whose `req_sel` does not have exactly one bit set, is dropped: no state change, no pulse, and read data 0.
- R9: While `soft_rst` is high at a clock edge, the configuration, modem, auxiliary-1 and auxiliary-2 registers are cleared. The diagnostic, LED and system-control registers keep their values. Any bus access in that cycle is dropped and no pulse is produced.
- R10: While `rst_n` is low, every register and every output is 0. This includes the diagnostic, LED and system-control registers.
- R11: A read request that is accepted returns the register zero-extended on `rd_data` in the next cycle. In every other cycle `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset with retention rule |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | 7 | One-hot region select |
| req_addr | input | AW (2) | Byte offset inside the region |
| req_size | input | 2 | Access size code |
| req_wdata | input | DW (32) | Write data, low-aligned |
| rd_data | output | DW (32) | Registered read data |
| pwr_failing | input | 1 | Power-failing indication |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Terminal-count strobe |
| shutdown_req | output | 1 | Shutdown request pulse |
| reset_req | output | 1 | System-reset request pulse |

## Verification
The hardest situation to reach is when a power-failing edge and an auxiliary-2 write land in the same cycle. The write then tries to clear or keep bit 5 while the input event reloads it, and the stored configuration enable has to be the value from before any configuration write in that cycle. The stimulus holds the input steady while it sets up the enable and the status bit. It then flips `pwr_failing` at the same falling edge that presents an auxiliary-2 clear. It also toggles the enable while the input stays asserted, to show that a level alone, without a change, does not set the status.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int NREG = 7;

  // region select indices
  localparam int RG_CFG    = 0;
  localparam int RG_DIAG   = 1;
  localparam int RG_MODEM  = 2;
  localparam int RG_LED    = 3;
  localparam int RG_SYSCTL = 4;
  localparam int RG_AUX1   = 5;
  localparam int RG_AUX2   = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_CMD_BIT  = 0;
  localparam logic [7:0] SYS_STAT_CODE = 8'h02;

  function automatic logic [1:0] region_size(input int idx);
    case (idx)
      RG_LED:    return SZ_HALF;
      RG_SYSCTL: return SZ_WORD;
      default:   return SZ_BYTE;
    endcase
  endfunction

  function automatic logic [7:0] aux1_store(input logic [7:0] d);
    logic [7:0] v;
    v = d;
    v[AUX1_TC_BIT] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] aux2_after_write(input logic [7:0] d, input logic pf_old);
    logic [7:0] v;
    v = '0;
    v[AUX2_OFF_BIT] = d[AUX2_OFF_BIT];
    v[AUX2_CLR_BIT] = d[AUX2_CLR_BIT];
    v[AUX2_PF_BIT]  = pf_old;
    if (d[AUX2_CLR_BIT]) begin
      v = '0;
      v[AUX2_OFF_BIT] = d[AUX2_OFF_BIT];
    end
    return v;
  endfunction
endpackage

// File: rtl/aux_bus_decode.sv
module aux_bus_decode
  import aux_sysctl_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [NREG-1:0] req_sel,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic            soft_rst,
  output logic [NREG-1:0] wr_hit,
  output logic [NREG-1:0] rd_hit
);
  logic common_ok;
  assign common_ok = req_valid && !soft_rst && $onehot(req_sel) && (req_addr == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    logic sel_ok;
    assign sel_ok    = common_ok && req_sel[i] && (req_size == region_size(i));
    assign wr_hit[i] = sel_ok && req_write;
    assign rd_hit[i] = sel_ok && !req_write;
  end
endmodule

// File: rtl/aux_pwr_ctrl.sv
module aux_pwr_ctrl
  import aux_sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       pwr_failing,
  input  logic [7:0] cfg_q,
  input  logic       aux2_wr,
  input  logic [7:0] wdata,
  output logic [7:0] aux2_q,
  output logic       pf_event,
  output logic       pf_irq,
  output logic       shutdown_req
);
  logic       pf_prev;
  logic [7:0] aux2_next;

  assign pf_event = (pwr_failing != pf_prev);

  always_comb begin
    aux2_next = aux2_q;
    if (aux2_wr) aux2_next = aux2_after_write(wdata, aux2_q[AUX2_PF_BIT]);
    if (pf_event) aux2_next[AUX2_PF_BIT] = pwr_failing & cfg_q[CFG_PIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_prev      <= 1'b0;
      aux2_q       <= '0;
      shutdown_req <= 1'b0;
    end else begin
      pf_prev      <= pwr_failing;
      shutdown_req <= aux2_wr && wdata[AUX2_OFF_BIT];
      if (soft_rst) aux2_q <= '0;
      else          aux2_q <= aux2_next;
    end
  end

  assign pf_irq = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PIE_BIT];
endmodule

// File: rtl/aux_reg_file.sv
module aux_reg_file
  import aux_sysctl_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LED_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [NREG-1:0] wr_hit,
  input  logic [NREG-1:0] rd_hit,
  input  logic [DW-1:0]   wdata,
  input  logic [7:0]      aux2_q,
  output logic [7:0]      cfg_q,
  output logic [7:0]      diag_q,
  output logic [7:0]      modem_q,
  output logic [7:0]      aux1_q,
  output logic [LED_W-1:0] led_q,
  output logic [7:0]      sysctl_q,
  output logic            tc_pulse,
  output logic            reset_req,
  output logic [DW-1:0]   rd_data
);
  logic [DW-1:0] rd_vals [NREG];
  logic [DW-1:0] rd_next;

  always_comb begin
    rd_vals[RG_CFG]    = DW'(cfg_q);
    rd_vals[RG_DIAG]   = DW'(diag_q);
    rd_vals[RG_MODEM]  = DW'(modem_q);
    rd_vals[RG_LED]    = DW'(led_q);
    rd_vals[RG_SYSCTL] = DW'(sysctl_q);
    rd_vals[RG_AUX1]   = DW'(aux1_q);
    rd_vals[RG_AUX2]   = DW'(aux2_q);
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit[i]) rd_next = rd_next | rd_vals[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      diag_q    <= '0;
      modem_q   <= '0;
      aux1_q    <= '0;
      led_q     <= '0;
      sysctl_q  <= '0;
      tc_pulse  <= 1'b0;
      reset_req <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_data   <= rd_next;
      tc_pulse  <= wr_hit[RG_AUX1] && wdata[AUX1_TC_BIT];
      reset_req <= wr_hit[RG_SYSCTL] && wdata[SYS_CMD_BIT];
      if (soft_rst) begin
        cfg_q   <= '0;
        modem_q <= '0;
        aux1_q  <= '0;
      end else begin
        if (wr_hit[RG_CFG])   cfg_q   <= wdata[7:0];
        if (wr_hit[RG_DIAG])  diag_q  <= wdata[7:0];
        if (wr_hit[RG_MODEM]) modem_q <= wdata[7:0];
        if (wr_hit[RG_LED])   led_q   <= wdata[LED_W-1:0];
        if (wr_hit[RG_AUX1])  aux1_q  <= aux1_store(wdata[7:0]);
        if (wr_hit[RG_SYSCTL] && wdata[SYS_CMD_BIT]) sysctl_q <= SYS_STAT_CODE;
      end
    end
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_sysctl_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [NREG-1:0] req_sel,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rd_data,
  input  logic            pwr_failing,
  output logic            pf_irq,
  output logic            tc_pulse,
  output logic            shutdown_req,
  output logic            reset_req
);
  localparam int LED_W = 16;

  // named internal events for the checker
  logic [NREG-1:0]  wr_hit;
  logic [NREG-1:0]  rd_hit;
  logic             pf_event;
  logic [7:0]       cfg_q, diag_q, modem_q, aux1_q, aux2_q, sysctl_q;
  logic [LED_W-1:0] led_q;

  aux_bus_decode #(.AW(AW)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .soft_rst  (soft_rst),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit)
  );

  aux_reg_file #(.DW(DW), .LED_W(LED_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .wdata     (req_wdata),
    .aux2_q    (aux2_q),
    .cfg_q     (cfg_q),
    .diag_q    (diag_q),
    .modem_q   (modem_q),
    .aux1_q    (aux1_q),
    .led_q     (led_q),
    .sysctl_q  (sysctl_q),
    .tc_pulse  (tc_pulse),
    .reset_req (reset_req),
    .rd_data   (rd_data)
  );

  aux_pwr_ctrl u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .pwr_failing  (pwr_failing),
    .cfg_q        (cfg_q),
    .aux2_wr      (wr_hit[RG_AUX2]),
    .wdata        (req_wdata[7:0]),
    .aux2_q       (aux2_q),
    .pf_event     (pf_event),
    .pf_irq       (pf_irq),
    .shutdown_req (shutdown_req)
  );
endmodule

// File: rtl/aux_sysctl_regs_chk.sv
module aux_sysctl_regs_chk
  import aux_sysctl_pkg::*;
#(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_rst,
  input logic [DW-1:0]   req_wdata,
  input logic [NREG-1:0] wr_hit,
  input logic [7:0]      cfg_q,
  input logic [7:0]      diag_q,
  input logic [7:0]      modem_q,
  input logic [7:0]      aux1_q,
  input logic [7:0]      aux2_q,
  input logic [7:0]      sysctl_q,
  input logic [15:0]     led_q,
  input logic            pf_irq,
  input logic            tc_pulse,
  input logic            shutdown_req,
  input logic            reset_req
);
  a_r1_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    pf_irq |-> (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PIE_BIT]));

  a_r1_irq_when_both: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PIE_BIT]) |-> pf_irq);

  a_r3_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(wr_hit[RG_AUX1] && req_wdata[AUX1_TC_BIT]));

  a_r3_tc_bit_unstored: assert property (@(posedge clk) disable iff (!rst_n)
    !aux1_q[AUX1_TC_BIT]);

  a_r4_aux2_field_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_q & 8'hDE) == 8'h00);

  a_r5_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_hit[RG_AUX2] && req_wdata[AUX2_OFF_BIT]));

  a_r6_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (sysctl_q == SYS_STAT_CODE && $past(wr_hit[RG_SYSCTL] && req_wdata[SYS_CMD_BIT])));

  a_r9_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> ($stable(diag_q) && $stable(sysctl_q) && $stable(led_q)));

  a_r9_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (cfg_q == 8'h00 && modem_q == 8'h00 && aux1_q == 8'h00 && aux2_q == 8'h00));
endmodule

bind aux_sysctl_regs aux_sysctl_regs_chk #(.DW(DW)) u_chk (.*);

// File: tb/aux_sysctl_regs_bench.sv
module aux_sysctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_sel = '0;
  logic [1:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        pwr_failing = 1'b0;
  logic        pf_irq, tc_pulse, shutdown_req, reset_req;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  aux_sysctl_regs u_aux_sysctl_regs (.*);

  // behavioural reference model
  logic [7:0]  m_cfg, m_diag, m_modem, m_aux1, m_aux2, m_sys;
  logic [15:0] m_led;
  logic        m_prev, m_irq, m_tc, m_shut, m_rst;
  logic [31:0] m_rd;

  function automatic int width_code(input int idx);
    if (idx == 3) return 1;
    if (idx == 4) return 2;
    return 0;
  endfunction

  task automatic cmp(input string name, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, name, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_cfg = 0; m_diag = 0; m_modem = 0; m_aux1 = 0; m_aux2 = 0; m_sys = 0; m_led = 0;
      m_prev = 0; m_tc = 0; m_shut = 0; m_rst = 0; m_rd = 0;
    end else begin
      automatic int   idx = -1;
      automatic bit   ok;
      automatic bit   ev = (pwr_failing != m_prev);
      automatic logic [7:0] cfg_before = m_cfg;
      automatic logic [7:0] d = req_wdata[7:0];
      m_prev = pwr_failing;
      m_tc = 0; m_shut = 0; m_rst = 0; m_rd = 0;
      for (int i = 0; i < 7; i++) if (req_sel[i]) idx = i;
      ok = req_valid && !soft_rst && ($countones(req_sel) == 1) && (req_addr == 0)
           && (idx >= 0) && (int'(req_size) == width_code(idx));
      if (soft_rst) begin
        m_cfg = 0; m_modem = 0; m_aux1 = 0; m_aux2 = 0;
      end else if (ok && !req_write) begin
        case (idx)
          0: m_rd = {24'h0, m_cfg};
          1: m_rd = {24'h0, m_diag};
          2: m_rd = {24'h0, m_modem};
          3: m_rd = {16'h0, m_led};
          4: m_rd = {24'h0, m_sys};
          5: m_rd = {24'h0, m_aux1};
          default: m_rd = {24'h0, m_aux2};
        endcase
      end else if (ok) begin
        case (idx)
          0: m_cfg = d;
          1: m_diag = d;
          2: m_modem = d;
          3: m_led = req_wdata[15:0];
          4: if (d[0]) begin m_sys = 8'h02; m_rst = 1; end
          5: begin m_aux1 = d & 8'hFD; m_tc = d[1]; end
          default: begin
            if (d[1]) m_aux2 = {7'h0, d[0]};
            else      m_aux2 = {2'b00, m_aux2[5], 3'b000, d[1:0]};
            m_shut = d[0];
          end
        endcase
      end
      if (!soft_rst && ev) m_aux2[5] = pwr_failing & cfg_before[3];
    end
    m_irq = m_aux2[5] & m_cfg[3];
    #2;
    vectors++;
    cmp("pf_irq", {31'h0, pf_irq}, {31'h0, m_irq});
    cmp("tc_pulse", {31'h0, tc_pulse}, {31'h0, m_tc});
    cmp("shutdown_req", {31'h0, shutdown_req}, {31'h0, m_shut});
    cmp("reset_req", {31'h0, reset_req}, {31'h0, m_rst});
    cmp("rd_data", rd_data, m_rd);
  end

  task automatic acc(input logic [6:0] sel, input bit wr, input logic [1:0] addr,
                     input logic [1:0] size, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = sel; req_addr = addr; req_size = size; req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_sel = '0; req_addr = 0; req_size = 0; req_wdata = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    acc(7'(1 << idx), 1, 0, 2'(width_code(idx)), data);
  endtask

  task automatic rd(input int idx);
    acc(7'(1 << idx), 0, 0, 2'(width_code(idx)), 0);
    @(negedge clk);
  endtask

  task automatic pf(input bit v);
    @(negedge clk);
    pwr_failing = v;
    @(negedge clk);
  endtask

  initial begin
    // R10: hard reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: plain stores and readback
    cur_req = "R11";
    wr(1, 32'h5A); wr(2, 32'hC3); wr(3, 32'hBEEF);
    for (int i = 0; i < 7; i++) rd(i);
    // R2 / R1: power-fail with enable
    cur_req = "R2";
    wr(0, 32'h08);
    pf(1); rd(6);
    cur_req = "R1";
    wr(0, 32'h00); wr(0, 32'h08);
    cur_req = "R2";
    pf(0); rd(6);
    wr(0, 32'h00); pf(1); rd(6);
    wr(0, 32'h08); rd(6);
    pf(0); pf(1);
    // R4: preserve and clear
    cur_req = "R4";
    wr(6, 32'h00); rd(6);
    wr(6, 32'hFC); rd(6);
    wr(6, 32'h02); rd(6);
    // R2 with a same-cycle aux2 clear and input edge
    cur_req = "R2";
    pf(0); pf(1);
    @(negedge clk);
    pwr_failing = 0; req_valid = 1; req_write = 1; req_sel = 7'h40; req_size = 0; req_wdata = 32'h02;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_sel = 0; req_wdata = 0;
    @(negedge clk);
    pwr_failing = 1; req_valid = 1; req_write = 1; req_sel = 7'h40; req_size = 0; req_wdata = 32'h02;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_sel = 0; req_wdata = 0;
    rd(6);
    // R5: shutdown requests
    cur_req = "R5";
    wr(6, 32'h01); rd(6); wr(6, 32'h03); rd(6); wr(6, 32'h00);
    // R3: terminal count
    cur_req = "R3";
    wr(5, 32'hFF); rd(5); wr(5, 32'h40); rd(5); wr(5, 32'h02); wr(5, 32'h02); rd(5);
    // R6: system control
    cur_req = "R6";
    wr(4, 32'hFFFF_FFFE); rd(4);
    wr(4, 32'h1); rd(4);
    // R7: nonzero offsets
    cur_req = "R7";
    acc(7'h08, 1, 2, 1, 32'h1234); acc(7'h08, 0, 2, 1, 0); rd(3);
    acc(7'h01, 1, 1, 0, 32'h11); rd(0);
    acc(7'h10, 0, 2, 2, 0);
    // R8: wrong width and bad selects
    cur_req = "R8";
    acc(7'h02, 1, 0, 2, 32'hFF); rd(1);
    acc(7'h08, 1, 0, 0, 32'h7777); acc(7'h08, 0, 0, 2, 0); rd(3);
    acc(7'h20, 1, 0, 1, 32'h02);
    acc(7'h06, 1, 0, 0, 32'h99); rd(1); rd(2);
    acc(7'h00, 1, 0, 0, 32'h99);
    // R9: soft reset retention, with a dropped access in the same cycle
    cur_req = "R9";
    wr(0, 32'h08); wr(5, 32'h81); wr(2, 32'h44); pf(0); pf(1);
    @(negedge clk);
    soft_rst = 1; req_valid = 1; req_write = 1; req_sel = 7'h02; req_size = 0; req_wdata = 32'h11;
    @(negedge clk);
    soft_rst = 0; req_valid = 0; req_write = 0; req_sel = 0; req_wdata = 0;
    for (int i = 0; i < 7; i++) rd(i);
    // R10: hard reset clears retained registers too
    cur_req = "R10";
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    for (int i = 0; i < 7; i++) rd(i);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule